// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block is a 16-bit timer that emits one delayed pulse for every accepted start. A configuration port sets a delay compare value and a period compare value. Once the timer is enabled it sits idle until a start arrives. A start can be a one-cycle software strobe or a selected edge on an asynchronous trigger pin. The counter then runs upward from zero. The pulse output rises when the count meets the delay value. When the count meets the period value, the pulse falls, the counter clears to zero and stops.

A toggle output inverts at the end of every run. Each compare match also gives a one-cycle interrupt strobe. Starts that arrive during a run are dropped. The compare values can be rewritten at any moment, and a new value applies from the next comparison. Clearing the enable abandons any run in progress and returns the block to idle.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: After reset, and in every cycle while `tmr_enable` is low, `pulse_out`, `toggle_out`, `irq_delay` and `irq_period` are all low. No start is accepted while disabled.
- R2: A start is accepted on the first rising clock edge that sees `sw_start` high while the timer is enabled and idle. With `pulse_oe` high, `pulse_out` rises `delay + 1` clock edges after that accepting edge.
- R3: `pulse_out` falls `period + 1` edges after the accepting edge, and the counter stops. If `delay` is equal to or greater than `period`, the pulse stays low for the whole run, because the fall takes priority over the rise.
- R4: `irq_delay` and `irq_period` are one-cycle strobes. Each is high in the same cycle as the pulse rise or pulse fall that its own match causes, and neither is raised outside a run.
- R5: `toggle_out` inverts once at the end of each run and is cleared while the timer is disabled.
- R6: `trig_in` passes through a two-flop synchronizer, so a qualifying edge is accepted on the third clock edge after the pin changes. `trig_edge` selects the qualifying edge: 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 both.
- R7: After a run has stopped with the counter at zero, a new start produces a new pulse with the same timing.
- R8: A software start or trigger edge that arrives during a run is ignored. The run ends at its original time and no second run follows.
- R9: The compare registers can be written in any cycle. A new period value written during a run sets where that same run ends.
- R10: When `pulse_oe` is low, `pulse_out` stays low, while counting and interrupts continue unchanged.
- R11: Starts are accepted only when `tmr_mode` equals 4'b0011. With any other value the timer never runs.
- R12: Dropping `tmr_enable` during a run forces `pulse_out` low on the next edge. A later start begins a fresh run with normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_enable | input | 1 | Operation enable; low resets the run |
| tmr_mode | input | 4 | Mode field; 4'b0011 selects one-shot |
| sw_start | input | 1 | Software start strobe |
| delay_wr | input | 1 | Write strobe for delay compare |
| delay_wdata | input | 16 | New delay compare value |
| period_wr | input | 1 | Write strobe for period compare |
| period_wdata | input | 16 | New period compare value |
| pulse_oe | input | 1 | Pulse output enable |
| trig_edge | input | 2 | Trigger edge select |
| trig_in | input | 1 | Asynchronous trigger pin |
| pulse_out | output | 1 | Delayed pulse |
| toggle_out | output | 1 | Inverts at every period match |
| irq_delay | output | 1 | Delay match strobe |
| irq_period | output | 1 | Period match strobe |

## Verification
The hardest case to reach from the ports is a start request that lands in the middle of a run. It only shows anything if it is placed exactly while the counter is busy, and it can only be seen as a missing second run. The scenario task therefore counts clocks from the accepted start. At a fixed cycle inside the window it fires both a software strobe and a trigger edge. It then watches long enough past the expected end to prove that exactly one period match occurred. A period rewrite during a run is placed in the same way, at a chosen cycle before the old match.

// File: rtl/ost_pkg.sv
`timescale 1ns/1ps
package ost_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [3:0] MODE_ONE_SHOT = 4'b0011;
endpackage

// File: rtl/ost_trig_edge.sv
`timescale 1ns/1ps
module ost_trig_edge
  import ost_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trig_in,
  input  edge_sel_e edge_sel,
  output logic      edge_det
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_d;
  logic             synced;
  logic             prev;

  always_comb begin
    chain_d = {chain_q[CHAIN-2:0], trig_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign synced = chain_q[SYNC_STAGES-1];
  assign prev   = chain_q[SYNC_STAGES];

  always_comb begin
    unique case (edge_sel)
      EDGE_RISE: edge_det = synced & ~prev;
      EDGE_FALL: edge_det = ~synced & prev;
      EDGE_BOTH: edge_det = synced ^ prev;
      default:   edge_det = 1'b0;
    endcase
  end
endmodule

// File: rtl/ost_cmp_regs.sv
`timescale 1ns/1ps
module ost_cmp_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         delay_wr,
  input  logic [W-1:0] delay_wdata,
  input  logic         period_wr,
  input  logic [W-1:0] period_wdata,
  output logic [W-1:0] delay_q,
  output logic [W-1:0] period_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        delay_q <= '0;
    else if (delay_wr) delay_q <= delay_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         period_q <= '0;
    else if (period_wr) period_q <= period_wdata;
  end
endmodule

// File: rtl/ost_count_core.sv
`timescale 1ns/1ps
module ost_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start_req,
  input  logic [W-1:0] delay_cmp,
  input  logic [W-1:0] period_cmp,
  output logic         pulse_q,
  output logic         toggle_q,
  output logic         irq_delay_q,
  output logic         irq_period_q
);
  localparam logic [W-1:0] IDLE_VAL = {W{1'b1}};
  localparam logic [W-1:0] ONE      = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         pulse_d, toggle_d, irq_delay_d, irq_period_d;
  logic         cnt_ce;
  logic         hit_delay, hit_period;

  assign hit_delay  = run_q && (cnt_q == delay_cmp);
  assign hit_period = run_q && (cnt_q == period_cmp);
  assign cnt_ce     = !en || run_q || start_req;

  always_comb begin
    cnt_d        = cnt_q;
    run_d        = run_q;
    pulse_d      = pulse_q;
    toggle_d     = toggle_q;
    irq_delay_d  = 1'b0;
    irq_period_d = 1'b0;
    if (!en) begin
      cnt_d    = IDLE_VAL;
      run_d    = 1'b0;
      pulse_d  = 1'b0;
      toggle_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q + ONE;
      if (hit_delay) begin
        pulse_d     = 1'b1;
        irq_delay_d = 1'b1;
      end
      if (hit_period) begin
        pulse_d      = 1'b0;
        toggle_d     = ~toggle_q;
        irq_period_d = 1'b1;
        cnt_d        = '0;
        run_d        = 1'b0;
      end
    end else if (start_req) begin
      cnt_d = '0;
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= IDLE_VAL;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q        <= 1'b0;
      pulse_q      <= 1'b0;
      toggle_q     <= 1'b0;
      irq_delay_q  <= 1'b0;
      irq_period_q <= 1'b0;
    end else begin
      run_q        <= run_d;
      pulse_q      <= pulse_d;
      toggle_q     <= toggle_d;
      irq_delay_q  <= irq_delay_d;
      irq_period_q <= irq_period_d;
    end
  end

  // R12
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!run_q && !pulse_q));

  // R3
  period_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period_q |-> (!run_q && cnt_q == '0 && !pulse_q));

  // R4
  period_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period_q |=> !irq_period_q);

  // R5
  toggle_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(toggle_q) && $past(en)) |-> irq_period_q);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> (cnt_q == W'($past(cnt_q) + ONE)));

  // R2
  pulse_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> (irq_delay_q && $past(run_q)));
endmodule

// File: rtl/oneshot_pulse_timer.sv
`timescale 1ns/1ps
module oneshot_pulse_timer
  import ost_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tmr_enable,
  input  logic [3:0]   tmr_mode,
  input  logic         sw_start,
  input  logic         delay_wr,
  input  logic [W-1:0] delay_wdata,
  input  logic         period_wr,
  input  logic [W-1:0] period_wdata,
  input  logic         pulse_oe,
  input  logic [1:0]   trig_edge,
  input  logic         trig_in,
  output logic         pulse_out,
  output logic         toggle_out,
  output logic         irq_delay,
  output logic         irq_period
);
  logic         trig_hit;
  logic         start_req;
  logic [W-1:0] delay_q, period_q;
  logic         pulse_q;

  ost_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_in  (trig_in),
    .edge_sel (edge_sel_e'(trig_edge)),
    .edge_det (trig_hit)
  );

  ost_cmp_regs #(.W(W)) u_cmp (
    .clk          (clk),
    .rst_n        (rst_n),
    .delay_wr     (delay_wr),
    .delay_wdata  (delay_wdata),
    .period_wr    (period_wr),
    .period_wdata (period_wdata),
    .delay_q      (delay_q),
    .period_q     (period_q)
  );

  assign start_req = (tmr_mode == MODE_ONE_SHOT) && (sw_start || trig_hit);

  ost_count_core #(.W(W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (tmr_enable),
    .start_req    (start_req),
    .delay_cmp    (delay_q),
    .period_cmp   (period_q),
    .pulse_q      (pulse_q),
    .toggle_q     (toggle_out),
    .irq_delay_q  (irq_delay),
    .irq_period_q (irq_period)
  );

  assign pulse_out = pulse_q & pulse_oe;

  // R11
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_mode != MODE_ONE_SHOT && $past(tmr_mode) != MODE_ONE_SHOT
     && !irq_delay && !irq_period && !pulse_q && $past(!pulse_q)) |=> !irq_delay);
endmodule

// File: tb/oneshot_pulse_timer_tb.sv
`timescale 1ns/1ps
module oneshot_pulse_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tmr_enable, sw_start, delay_wr, period_wr, pulse_oe, trig_in;
  logic [3:0]  tmr_mode;
  logic [15:0] delay_wdata, period_wdata;
  logic [1:0]  trig_edge;
  logic        pulse_out, toggle_out, irq_delay, irq_period;

  int n_checks = 0;
  int n_fail   = 0;
  int rise_k, fall_k, irqd_k, irqp_k, irqd_n, irqp_n;

  always #2 clk = ~clk;

  oneshot_pulse_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_enable(tmr_enable), .tmr_mode(tmr_mode),
    .sw_start(sw_start), .delay_wr(delay_wr), .delay_wdata(delay_wdata),
    .period_wr(period_wr), .period_wdata(period_wdata), .pulse_oe(pulse_oe),
    .trig_edge(trig_edge), .trig_in(trig_in), .pulse_out(pulse_out),
    .toggle_out(toggle_out), .irq_delay(irq_delay), .irq_period(irq_period)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cmp(input int dly, input int per);
    @(negedge clk);
    delay_wr = 1'b1; delay_wdata = 16'(dly);
    period_wr = 1'b1; period_wdata = 16'(per);
    @(negedge clk);
    delay_wr = 1'b0; period_wr = 1'b0;
  endtask

  // Counts negedges after the stimulus placed at k = 0
  task automatic measure(input int window, input int inj_k,
                         input int wrp_k, input int wrp_val);
    rise_k = -1; fall_k = -1; irqd_k = -1; irqp_k = -1; irqd_n = 0; irqp_n = 0;
    for (int k = 1; k <= window; k++) begin
      @(posedge clk); @(negedge clk);
      sw_start = 1'b0; period_wr = 1'b0;
      if (pulse_out && rise_k < 0) rise_k = k;
      if (!pulse_out && rise_k >= 0 && fall_k < 0) fall_k = k;
      if (irq_delay)  begin irqd_n++; if (irqd_k < 0) irqd_k = k; end
      if (irq_period) begin irqp_n++; if (irqp_k < 0) irqp_k = k; end
      if (k == inj_k) begin sw_start = 1'b1; trig_in = ~trig_in; end
      if (k == wrp_k) begin period_wr = 1'b1; period_wdata = 16'(wrp_val); end
    end
  endtask

  task automatic sw_go();
    @(negedge clk);
    sw_start = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 pulse after reset", pulse_out, 0);
    chk("R1 toggle after reset", toggle_out, 0);
    chk("R1 irqs after reset", irq_delay | irq_period, 0);
    set_cmp(2, 4);
    sw_go();
    measure(10, -1, -1, 0);
    chk("R1 no run while disabled", irqp_n + irqd_n + (rise_k >= 0 ? 1 : 0), 0);
    @(negedge clk); tmr_enable = 1'b1;
    measure(8, -1, -1, 0);
    chk("R1 idle when enabled without start", irqp_n + irqd_n, 0);
  endtask

  task automatic t_sw_run();
    set_cmp(3, 7);
    sw_go();
    measure(14, -1, -1, 0);
    chk("R2 rise cycle", rise_k, 5);
    chk("R3 fall cycle", fall_k, 9);
    chk("R4 irq_delay cycle", irqd_k, 5);
    chk("R4 irq_period cycle", irqp_k, 9);
    chk("R4 one strobe each", irqd_n * 10 + irqp_n, 11);
    chk("R5 toggle after run 1", toggle_out, 1);
  endtask

  task automatic t_second_run();
    set_cmp(0, 2);
    sw_go();
    measure(8, -1, -1, 0);
    chk("R7 rerun rise", rise_k, 2);
    chk("R7 rerun fall", fall_k, 4);
    chk("R5 toggle after run 2", toggle_out, 0);
  endtask

  task automatic t_trig_edges();
    set_cmp(2, 5);
    trig_edge = 2'b01;
    @(negedge clk); trig_in = 1'b1;
    measure(12, -1, -1, 0);
    chk("R6 rising trigger rise", rise_k, 6);
    chk("R6 rising trigger fall", fall_k, 9);
    @(negedge clk); trig_in = 1'b0;
    measure(12, -1, -1, 0);
    chk("R6 falling edge ignored in rise mode", irqp_n, 0);
    trig_edge = 2'b10;
    @(negedge clk); trig_in = 1'b1;
    measure(12, -1, -1, 0);
    chk("R6 rising edge ignored in fall mode", irqp_n, 0);
    @(negedge clk); trig_in = 1'b0;
    measure(12, -1, -1, 0);
    chk("R6 falling trigger rise", rise_k, 6);
    trig_edge = 2'b00;
    @(negedge clk); trig_in = 1'b1;
    measure(12, -1, -1, 0);
    chk("R6 no edge selected", irqp_n, 0);
    trig_edge = 2'b11;
    @(negedge clk); trig_in = 1'b0;
    measure(12, -1, -1, 0);
    chk("R6 both-edge trigger fall", fall_k, 9);
    trig_edge = 2'b01;
  endtask

  task automatic t_retrigger();
    set_cmp(4, 10);
    sw_go();
    measure(24, 6, -1, 0);
    chk("R8 fall unchanged", fall_k, 12);
    chk("R8 single run", irqp_n, 1);
  endtask

  task automatic t_rewrite();
    set_cmp(2, 6);
    sw_go();
    measure(18, -1, 3, 12);
    chk("R9 period rewritten mid-run", fall_k, 14);
    chk("R9 one period match", irqp_n, 1);
  endtask

  task automatic t_oe_off();
    set_cmp(1, 4);
    pulse_oe = 1'b0;
    sw_go();
    measure(10, -1, -1, 0);
    chk("R10 pulse held low", rise_k, -1);
    chk("R10 irq_delay still fires", irqd_k, 3);
    chk("R10 irq_period still fires", irqp_k, 6);
    pulse_oe = 1'b1;
  endtask

  task automatic t_equal_and_over();
    set_cmp(5, 5);
    sw_go();
    measure(10, -1, -1, 0);
    chk("R3 equal compares keep pulse low", rise_k, -1);
    chk("R4 equal compares delay strobe", irqd_k, 7);
    chk("R4 equal compares period strobe", irqp_k, 7);
    set_cmp(9, 4);
    sw_go();
    measure(14, -1, -1, 0);
    chk("R3 delay beyond period no pulse", rise_k, -1);
    chk("R4 delay beyond period no strobe", irqd_n, 0);
    chk("R3 delay beyond period end", irqp_k, 6);
  endtask

  task automatic t_mode();
    set_cmp(1, 3);
    tmr_mode = 4'b0000;
    sw_go();
    measure(10, -1, -1, 0);
    chk("R11 other mode no run", irqd_n + irqp_n, 0);
    tmr_mode = 4'b0011;
  endtask

  task automatic t_disable();
    set_cmp(1, 20);
    sw_go();
    measure(5, -1, -1, 0);
    chk("R12 pulse high before disable", pulse_out, 1);
    tmr_enable = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R12 pulse low after disable", pulse_out, 0);
    chk("R5 toggle cleared by disable", toggle_out, 0);
    measure(25, -1, -1, 0);
    chk("R12 no period match after disable", irqp_n, 0);
    tmr_enable = 1'b1;
    sw_go();
    measure(25, -1, -1, 0);
    chk("R12 fresh run rise", rise_k, 3);
    chk("R12 fresh run fall", fall_k, 22);
  endtask

  initial begin
    rst_n = 1'b0; tmr_enable = 1'b0; tmr_mode = 4'b0011; sw_start = 1'b0;
    delay_wr = 1'b0; delay_wdata = '0; period_wr = 1'b0; period_wdata = '0;
    pulse_oe = 1'b1; trig_edge = 2'b01; trig_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sw_run();
    t_second_run();
    t_trig_edges();
    t_retrigger();
    t_rewrite();
    t_oe_off();
    t_equal_and_over();
    t_mode();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule